// File: doc/BRIEF.md
# Serial EEPROM Write Front-End (two-wire slave)

This block is the bus-facing write path of an 8192 x 8 serial EEPROM. It watches the two-wire bus (clock and data), both sampled into the system clock, and pulls the data line low through an open-drain enable whenever it acknowledges. A transfer opens with a START, carries a device address byte that must match the fixed family code and the three chip-select pins, then two memory address bytes, then the write data.

Each accepted data byte is handed to the page buffer as a one-cycle strobe. The strobe carries the byte, its 5-bit position inside the 32-byte page, and the fixed page number. The in-page position advances only after the byte has been acknowledged, and it wraps from 31 back to 0 without touching the page number. A STOP that follows at least one data byte raises a single-cycle commit strobe that starts the programming cycle. While the programming cycle runs, an input from the programming logic tells the block to refuse every byte.

Top module: `i2c_eeprom_wr_front`

## Requirements
- R1: After reset the open-drain enable, the data strobe and the commit strobe are all low.
- R2: A START (data falling while clock is high) from any state, including mid-transfer, restarts reception at the device address byte and releases the data line; a STOP (data rising while clock is high) returns the block to idle.
- R3: The device address byte is accepted only when bits 7:4 are 1010, bits 3:1 equal the chip-select pins and bit 0 is 0 (write); otherwise it is not acknowledged and all following bytes are ignored until the next START.
- R4: Bytes arrive MSB first. Every accepted byte is acknowledged by holding the open-drain enable high from the clock fall after its 8th bit to the clock fall after the 9th clock.
- R5: Bits 4:0 of the first address byte give A12..A8, and the second address byte gives A7..A0. The page output shows A12..A5, and the first data byte lands at offset A4..A0.
- R6: Each accepted data byte produces a one-cycle data strobe, raised together with its acknowledge, that carries the byte and its current in-page offset.
- R7: The offset increments by one after each acknowledged data byte, in 5 bits only: offset 31 is followed by offset 0, and the page output stays unchanged.
- R8: When the busy input is high at the moment a byte would be acknowledged, the byte is not acknowledged, no data strobe is raised, and the block goes idle.
- R9: A STOP that follows at least one accepted data byte of the current transfer gives exactly one one-cycle commit pulse; a STOP with no accepted data byte gives none.
- R10: After a repeated START the new address bytes fully replace the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls the data line low (acknowledge) |
| cs_i | input | 3 | Static chip-select pins |
| busy_i | input | 1 | Programming cycle in progress; refuse bytes |
| wr_valid_o | output | 1 | One-cycle strobe per accepted data byte |
| wr_data_o | output | 8 | Data byte for the page buffer |
| wr_offset_o | output | 5 | Offset of the byte inside its page |
| wr_page_o | output | 8 | Page number A12..A5 |
| commit_o | output | 1 | One-cycle request to start programming |

## Verification
Every result follows a bus edge by three system clocks: two synchronizer flops, then the edge register feeding the controller. So the acknowledge, the data strobe and the commit strobe appear three cycles after the clock or data change that causes them. The bench holds each bus clock phase for eight system clocks, so all results have settled before any bus change that depends on them. It reads the acknowledge at the middle of the ninth clock's high phase, on a falling system clock edge. A monitor on the falling edge records every data and commit strobe, and the records are compared with values computed from the address and data the bench sent.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_DATA
   } phase_t;

   localparam logic [3:0] DEV_FAMILY = 4'b1010;
   localparam int         CSEL_W     = 3;
   localparam int         BYTE_W     = 8;
endpackage

// File: rtl/eepw_bus_sync.sv
module eepw_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eepw_bus_sync: STAGES must be at least 2");
   end

   logic [1:0] raw;
   logic [1:0] synced;
   logic [1:0] prev;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 2'b11;
      else        prev <= synced;
   end

   assign sda_s     = synced[1];
   assign scl_rise  = synced[0] & ~prev[0];
   assign scl_fall  = ~synced[0] & prev[0];
   assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
   assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
   import eepw_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int OFF_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sda_s,
   input  logic                     scl_rise,
   input  logic                     scl_fall,
   input  logic                     start_det,
   input  logic                     stop_det,
   input  logic [CSEL_W-1:0]        cs_i,
   input  logic                     busy_i,
   output logic                     sda_oe,
   output logic                     wr_valid,
   output logic [BYTE_W-1:0]        wr_data,
   output logic [OFF_W-1:0]         wr_off,
   output logic [ADDR_W-OFF_W-1:0]  page,
   output logic                     commit
);
   localparam int         HI_W   = ADDR_W - BYTE_W;
   localparam int         PAGE_W = ADDR_W - OFF_W;
   localparam logic [3:0] BITS   = 4'd8;

   phase_t              ph;
   logic [BYTE_W-1:0]   shreg;
   logic [3:0]          bitcnt;
   logic                in_ack;
   logic                inc_pend;
   logic                had_data;
   logic [HI_W-1:0]     hi_q;
   logic [OFF_W-1:0]    off_q;
   logic [PAGE_W-1:0]   page_q;
   logic                dev_hit;

   assign dev_hit = (shreg[7:4] == DEV_FAMILY) && (shreg[3:1] == cs_i) && !shreg[0];
   assign page    = page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         shreg    <= '0;
         bitcnt   <= '0;
         in_ack   <= 1'b0;
         inc_pend <= 1'b0;
         had_data <= 1'b0;
         hi_q     <= '0;
         off_q    <= '0;
         page_q   <= '0;
         sda_oe   <= 1'b0;
         wr_valid <= 1'b0;
         wr_data  <= '0;
         wr_off   <= '0;
         commit   <= 1'b0;
      end else begin
         wr_valid <= 1'b0;
         commit   <= 1'b0;
         if (start_det) begin
            ph       <= PH_DEV;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            inc_pend <= 1'b0;
            had_data <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            commit   <= (ph == PH_DATA) && had_data;
            ph       <= PH_IDLE;
            in_ack   <= 1'b0;
            inc_pend <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (ph != PH_IDLE) begin
            if (scl_rise && !in_ack && bitcnt != BITS) begin
               shreg  <= {shreg[BYTE_W-2:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end
            if (scl_fall) begin
               if (in_ack) begin
                  sda_oe   <= 1'b0;
                  in_ack   <= 1'b0;
                  bitcnt   <= '0;
                  inc_pend <= 1'b0;
                  if (inc_pend) off_q <= off_q + 1'b1;
               end else if (bitcnt == BITS) begin
                  if (busy_i || (ph == PH_DEV && !dev_hit)) begin
                     ph <= PH_IDLE;
                  end else begin
                     sda_oe <= 1'b1;
                     in_ack <= 1'b1;
                     unique case (ph)
                        PH_DEV: ph <= PH_AHI;
                        PH_AHI: begin
                           hi_q <= shreg[HI_W-1:0];
                           ph   <= PH_ALO;
                        end
                        PH_ALO: begin
                           page_q <= {hi_q, shreg[BYTE_W-1:OFF_W]};
                           off_q  <= shreg[OFF_W-1:0];
                           ph     <= PH_DATA;
                        end
                        PH_DATA: begin
                           wr_valid <= 1'b1;
                           wr_data  <= shreg;
                           wr_off   <= off_q;
                           had_data <= 1'b1;
                           inc_pend <= 1'b1;
                        end
                        default: ph <= PH_IDLE;
                     endcase
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2c_eeprom_wr_front.sv
module i2c_eeprom_wr_front #(
   parameter int ADDR_W      = 13,
   parameter int PAGE_BYTES  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  scl_i,
   input  logic                                  sda_i,
   output logic                                  sda_oe_o,
   input  logic [2:0]                            cs_i,
   input  logic                                  busy_i,
   output logic                                  wr_valid_o,
   output logic [7:0]                            wr_data_o,
   output logic [$clog2(PAGE_BYTES)-1:0]         wr_offset_o,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  wr_page_o,
   output logic                                  commit_o
);
   localparam int OFF_W = $clog2(PAGE_BYTES);

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("i2c_eeprom_wr_front: ADDR_W must lie in 9..16");
   end
   if ((1 << OFF_W) != PAGE_BYTES || OFF_W < 1 || OFF_W > 7) begin : g_bad_page
      $error("i2c_eeprom_wr_front: PAGE_BYTES must be a power of two from 2 to 128");
   end

   logic sda_s;
   logic scl_rise;
   logic scl_fall;
   logic start_det;
   logic stop_det;

   eepw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   eepw_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .cs_i      (cs_i),
      .busy_i    (busy_i),
      .sda_oe    (sda_oe_o),
      .wr_valid  (wr_valid_o),
      .wr_data   (wr_data_o),
      .wr_off    (wr_offset_o),
      .page      (wr_page_o),
      .commit    (commit_o)
   );
endmodule

// File: rtl/eepw_chk.sv
module eepw_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic busy_i,
   input logic sda_oe_o,
   input logic wr_valid_o,
   input logic commit_o,
   input logic start_det,
   input logic stop_det
);
   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o); // R2
   AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_i); // R4
   AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> sda_oe_o); // R6
   AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(busy_i)); // R8
   AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(stop_det)); // R9
   AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o); // R9
endmodule

bind i2c_eeprom_wr_front eepw_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_i      (scl_i),
   .busy_i     (busy_i),
   .sda_oe_o   (sda_oe_o),
   .wr_valid_o (wr_valid_o),
   .commit_o   (commit_o),
   .start_det  (start_det),
   .stop_det   (stop_det)
);

// File: tb/i2c_eeprom_wr_front_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_wr_front_tb;
   localparam int H = 8;
   localparam logic [2:0] CS = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic busy = 1'b0;
   logic sda_oe;
   logic wr_valid;
   logic [7:0] wr_data;
   logic [4:0] wr_off;
   logic [7:0] wr_page;
   logic commit;
   logic sda_bus;

   int total = 0;
   int bad = 0;
   int cap_n = 0;
   int commit_n = 0;
   logic [7:0] cap_data [0:511];
   logic [4:0] cap_off  [0:511];
   logic [7:0] cap_page [0:511];

   always #2.5 clk = ~clk;
   assign sda_bus = m_sda & ~sda_oe;

   i2c_eeprom_wr_front u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .cs_i(CS), .busy_i(busy), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
      .wr_offset_o(wr_off), .wr_page_o(wr_page), .commit_o(commit)
   );

   always @(negedge clk) begin
      if (rst_n && wr_valid && cap_n < 512) begin
         cap_data[cap_n] = wr_data;
         cap_off[cap_n]  = wr_off;
         cap_page[cap_n] = wr_page;
         cap_n++;
      end
      if (rst_n && commit) commit_n++;
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(H);
         m_scl = 1'b1; tick(H);
         m_scl = 1'b0;
      end
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H/2);
      ack = ~sda_bus;
      tick(H/2);
      m_scl = 1'b0;
   endtask

   task automatic expect_ack(input logic [7:0] b, input logic exp, input string tag);
      logic a;
      send_byte(b, a);
      check(tag, int'(a), int'(exp));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
   end

   initial begin
      int c0;
      int n0;
      tick(4);
      check("R1 sda_oe at reset", int'(sda_oe), 0);
      check("R1 wr_valid at reset", int'(wr_valid), 0);
      check("R1 commit at reset", int'(commit), 0);
      rst_n = 1'b1;
      tick(10);

      // R5 R6 R9: single byte write, A = {11010, 01000111}
      c0 = commit_n; n0 = cap_n;
      bus_start();
      expect_ack({4'b1010, CS, 1'b0}, 1'b1, "R4 dev ack");
      expect_ack(8'h1A, 1'b1, "R4 hi ack");
      expect_ack(8'h47, 1'b1, "R4 lo ack");
      expect_ack(8'h5C, 1'b1, "R4 data ack");
      bus_stop();
      tick(6);
      check("R6 one strobe", cap_n - n0, 1);
      check("R6 data", int'(cap_data[n0]), 8'h5C);
      check("R5 offset", int'(cap_off[n0]), 5'd7);
      check("R5 page", int'(cap_page[n0]), {5'h1A, 3'd2});
      check("R9 commit count", commit_n - c0, 1);

      // R3: every chip-select value, plus wrong family code and read bit
      for (int k = 0; k < 8; k++) begin
         bus_start();
         expect_ack({4'b1010, 3'(k), 1'b0}, (3'(k) == CS), "R3 chip select");
         bus_stop();
      end
      bus_start();
      expect_ack({4'b1011, CS, 1'b0}, 1'b0, "R3 family code");
      bus_stop();
      bus_start();
      expect_ack({4'b1010, CS, 1'b1}, 1'b0, "R3 read bit");
      // R3: bytes after a refused address are ignored
      n0 = cap_n; c0 = commit_n;
      expect_ack(8'h00, 1'b0, "R3 ignored hi");
      expect_ack(8'h00, 1'b0, "R3 ignored lo");
      expect_ack(8'h33, 1'b0, "R3 ignored data");
      bus_stop();
      tick(6);
      check("R3 no strobe", cap_n - n0, 0);
      check("R3 no commit", commit_n - c0, 0);

      // R7: every start offset, three bytes each, wrap inside the page
      for (int so = 0; so < 32; so++) begin
         logic [7:0] hi;
         logic [7:0] lo;
         hi = 8'((so * 3) & 31);
         lo = {3'(so % 8), 5'(so)};
         n0 = cap_n; c0 = commit_n;
         bus_start();
         expect_ack({4'b1010, CS, 1'b0}, 1'b1, "R4 dev ack");
         expect_ack(hi, 1'b1, "R4 hi ack");
         expect_ack(lo, 1'b1, "R4 lo ack");
         for (int k = 0; k < 3; k++)
            expect_ack(8'((so * 7 + k * 13) & 255), 1'b1, "R4 data ack");
         bus_stop();
         tick(6);
         check("R6 strobe count", cap_n - n0, 3);
         check("R9 commit count", commit_n - c0, 1);
         for (int k = 0; k < 3; k++) begin
            check("R6 data", int'(cap_data[n0 + k]), (so * 7 + k * 13) & 255);
            check("R7 offset", int'(cap_off[n0 + k]), (so + k) % 32);
            check("R7 page fixed", int'(cap_page[n0 + k]), int'({hi[4:0], lo[7:5]}));
         end
      end

      // R9: STOP before any data byte
      c0 = commit_n;
      bus_start();
      expect_ack({4'b1010, CS, 1'b0}, 1'b1, "R4 dev ack");
      expect_ack(8'h01, 1'b1, "R4 hi ack");
      expect_ack(8'h02, 1'b1, "R4 lo ack");
      bus_stop();
      tick(6);
      check("R9 no commit without data", commit_n - c0, 0);

      // R8: busy refuses device byte and data byte
      busy = 1'b1;
      bus_start();
      expect_ack({4'b1010, CS, 1'b0}, 1'b0, "R8 dev refused");
      bus_stop();
      busy = 1'b0;
      n0 = cap_n; c0 = commit_n;
      bus_start();
      expect_ack({4'b1010, CS, 1'b0}, 1'b1, "R4 dev ack");
      expect_ack(8'h03, 1'b1, "R4 hi ack");
      expect_ack(8'h10, 1'b1, "R4 lo ack");
      busy = 1'b1;
      expect_ack(8'hA5, 1'b0, "R8 data refused");
      busy = 1'b0;
      bus_stop();
      tick(6);
      check("R8 no strobe", cap_n - n0, 0);
      check("R8 no commit", commit_n - c0, 0);

      // R10 R2: repeated START replaces address
      n0 = cap_n; c0 = commit_n;
      bus_start();
      expect_ack({4'b1010, CS, 1'b0}, 1'b1, "R4 dev ack");
      expect_ack(8'h1F, 1'b1, "R4 hi ack");
      bus_start();
      expect_ack({4'b1010, CS, 1'b0}, 1'b1, "R2 dev ack after restart");
      expect_ack(8'h04, 1'b1, "R4 hi ack");
      expect_ack(8'hBE, 1'b1, "R4 lo ack");
      expect_ack(8'h99, 1'b1, "R4 data ack");
      expect_ack(8'h77, 1'b1, "R4 data ack");
      bus_stop();
      tick(6);
      check("R10 strobe count", cap_n - n0, 2);
      check("R10 page", int'(cap_page[n0]), {5'h04, 3'd5});
      check("R10 offset", int'(cap_off[n0]), 5'd30);
      check("R7 next offset", int'(cap_off[n0 + 1]), 5'd31);
      check("R10 data", int'(cap_data[n0 + 1]), 8'h77);
      check("R2 idle after stop", int'(sda_oe), 0);
      check("R9 commit count", commit_n - c0, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule